// File: doc/BRIEF.md
# LPC I/O Cycle Target Responder

This block is the target side of a low-pin-count host bus, restricted to I/O cycles. It watches a 4-bit shared nibble bus and an active-low frame strobe. It decodes I/O reads and I/O writes whose 16-bit address lies inside a window set by parameters. For each such cycle it completes the handshake on the nibble bus and moves one byte across a small local interface. Cycles of any other type, and cycles that fall outside the window, pass by without the block ever driving the bus.

On a read, the block asks its local side for a byte. It then sends a fixed run of "not ready" sync nibbles, a "ready" sync nibble, the byte as two nibbles, and its own turnaround. On a write, it collects the byte from the bus and hands it to the local side. It then sends the same sync run, followed by its turnaround. The block only drives the bus when `bus_oe_o` is high. Pulling the frame strobe low at any time abandons the cycle in progress and restarts decoding.

The control is a single state machine with these states:
- `ST_IDLE`
- `ST_CTYPE` (type/direction nibble)
- `ST_ADDR` (four address nibbles)
- `ST_WDATA` (two write nibbles)
- `ST_HTAR1` and `ST_HTAR2` (host turnaround)
- `ST_SYNC_WAIT` (repeated not-ready sync)
- `ST_SYNC_OK` (ready sync)
- `ST_RDATA_LO` and `ST_RDATA_HI`
- `ST_TTAR` (target drives 1111)
- `ST_TFLOAT` (target released)

The transitions are:
- Frame strobe low with nibble 0000: any state goes to `ST_CTYPE`.
- Frame strobe low with any other nibble: any state goes to `ST_IDLE`.
- `ST_CTYPE` goes to `ST_ADDR` on an I/O type, and to `ST_IDLE` otherwise.
- `ST_ADDR` goes, after the fourth nibble, to `ST_WDATA` (write hit), `ST_HTAR1` (read hit) or `ST_IDLE` (miss).
- `ST_WDATA` goes to `ST_HTAR1` after two nibbles.
- `ST_HTAR1` goes to `ST_HTAR2`, and `ST_HTAR2` goes to `ST_SYNC_WAIT`.
- `ST_SYNC_WAIT` goes to `ST_SYNC_OK` once the wait count is reached.
- `ST_SYNC_OK` goes to `ST_RDATA_LO` on a read and to `ST_TTAR` on a write.
- `ST_RDATA_LO` goes to `ST_RDATA_HI`, and `ST_RDATA_HI` goes to `ST_TTAR`.
- `ST_TTAR` goes to `ST_TFLOAT`, and `ST_TFLOAT` goes to `ST_IDLE`.

Top module: `lpcio_responder`

## Requirements
- R1: After reset, `bus_oe_o`, `loc_rd_o` and `loc_wr_o` are all low, and they stay low while the frame strobe is idle.
- R2: A cycle starts only when the nibble present on the last clock of a low frame strobe is 0000. If the frame strobe is low for several clocks, earlier nibbles do not matter. A last nibble other than 0000 gives no response.
- R3: The type nibble has bits [3:2]=00 for an I/O cycle, and bit [1] is 0 for a read and 1 for a write. Any other value of bits [3:2] is ignored: the bus is never driven and no strobe is given.
- R4: The four nibbles after the type nibble form the 16-bit address, most significant nibble first. This address is presented on `loc_addr_o` during the local strobe.
- R5: Only addresses from WIN_BASE to WIN_BASE+WIN_SIZE-1 get a response. By default this is 0x0060 to 0x006F. Outside that range the bus stays undriven and no strobe is given.
- R6: After the address (read) or the write data (write), the two host turnaround clocks leave the bus undriven. The block then drives exactly WAIT_SYNCS clocks of 0110 (default 3), then one clock of 0000.
- R7: On a read, `loc_rd_o` pulses for one clock during the first host turnaround clock, and `loc_rdata_i` is taken at the end of that clock. The byte is driven on the two clocks after the 0000 sync, low nibble first.
- R8: On a write, the two nibbles after the address are the data byte, low nibble first. `loc_wr_o` pulses for one clock during the first host turnaround clock, with the byte on `loc_wdata_o`.
- R9: After the last sync (write) or the last data nibble (read), the block drives 1111 for one clock and then releases the bus. `bus_oe_o` is high only during sync, data and that one turnaround clock.
- R10: A low frame strobe in any state ends the current cycle, and `bus_oe_o` is low on the next clock. If the nibble is 0000, decoding starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_n_i | input | 1 | Synchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame strobe from the host |
| bus_nib_i | input | 4 | Nibble bus as seen by the target |
| bus_nib_o | output | 4 | Nibble the target drives |
| bus_oe_o | output | 1 | Target drive enable for the nibble bus |
| loc_addr_o | output | 16 | Decoded I/O address |
| loc_wdata_o | output | 8 | Byte written by the host |
| loc_wr_o | output | 1 | One-clock write strobe |
| loc_rd_o | output | 1 | One-clock read strobe |
| loc_rdata_i | input | 8 | Byte returned by the local side |

## Verification
A wrong state in this machine shows at the bus on the very clock it happens. If the state lingers or is skipped, the run of 0110 nibbles has the wrong length. Data nibbles in the wrong order show as a swapped byte. A missed abort shows as `bus_oe_o` still high one clock after the frame strobe falls. A wrongly taken cycle shows as a drive or a strobe where none is allowed. The bench compares every target-driven clock against the expected nibble. It also matches every local strobe against a queue of expected transfers, so any error appears within the same cycle of at most about fifteen clocks.

// File: rtl/lpcio_pkg.sv
package lpcio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_WDATA,
        ST_HTAR1,
        ST_HTAR2,
        ST_SYNC_WAIT,
        ST_SYNC_OK,
        ST_RDATA_LO,
        ST_RDATA_HI,
        ST_TTAR,
        ST_TFLOAT
    } lpcio_state_e;

    localparam logic [3:0] NIB_START   = 4'b0000;
    localparam logic [3:0] NIB_WAIT    = 4'b0110;
    localparam logic [3:0] NIB_READY   = 4'b0000;
    localparam logic [3:0] NIB_TAR     = 4'b1111;

endpackage

// File: rtl/lpcio_win_decode.sv
module lpcio_win_decode #(
    parameter logic [15:0] WIN_BASE = 16'h0060,
    parameter int          WIN_SIZE = 16
) (
    input  logic [15:0] addr_i,
    output logic        hit_o
);
    localparam logic [16:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [16:0] WIN_HI = WIN_LO + 17'(WIN_SIZE);

    always_comb begin
        hit_o = ({1'b0, addr_i} >= WIN_LO) && ({1'b0, addr_i} < WIN_HI);
    end
endmodule

// File: rtl/lpcio_wait_cnt.sv
module lpcio_wait_cnt #(
    parameter int WAIT_SYNCS = 3
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (WAIT_SYNCS < 2) ? 1 : $clog2(WAIT_SYNCS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_SYNCS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb done_o = (cnt_q == LAST);

    // R6: the wait counter never runs past its last value
    p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_q <= LAST);

    // R6: a run that has not reached the count keeps going up by one
    p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lpcio_responder.sv
module lpcio_responder
    import lpcio_pkg::*;
#(
    parameter logic [15:0] WIN_BASE   = 16'h0060,
    parameter int          WIN_SIZE   = 16,
    parameter int          WAIT_SYNCS = 3
) (
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        frame_n_i,
    input  logic [3:0]  bus_nib_i,
    output logic [3:0]  bus_nib_o,
    output logic        bus_oe_o,
    output logic [15:0] loc_addr_o,
    output logic [7:0]  loc_wdata_o,
    output logic        loc_wr_o,
    output logic        loc_rd_o,
    input  logic [7:0]  loc_rdata_i
);
    localparam logic [16:0] CHK_LO = {1'b0, WIN_BASE};
    localparam logic [16:0] CHK_HI = CHK_LO + 17'(WIN_SIZE);

    lpcio_state_e state_q, state_d;
    logic [15:0]  addr_q;
    logic [15:0]  addr_next;
    logic [7:0]   wdata_q;
    logic [7:0]   rdata_q;
    logic [1:0]   nib_cnt_q;
    logic         dir_wr_q;
    logic         win_hit;
    logic         wait_done;

    always_comb addr_next = {addr_q[11:0], bus_nib_i};

    lpcio_win_decode #(
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_win (
        .addr_i (addr_next),
        .hit_o  (win_hit)
    );

    lpcio_wait_cnt #(
        .WAIT_SYNCS (WAIT_SYNCS)
    ) u_wait (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (state_q == ST_SYNC_WAIT),
        .done_o  (wait_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!frame_n_i) begin
            state_d = (bus_nib_i == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_CTYPE:     state_d = (bus_nib_i[3:2] == 2'b00) ? ST_ADDR : ST_IDLE;
                ST_ADDR: begin
                    if (nib_cnt_q == 2'd3) begin
                        if (!win_hit)      state_d = ST_IDLE;
                        else if (dir_wr_q) state_d = ST_WDATA;
                        else               state_d = ST_HTAR1;
                    end
                end
                ST_WDATA:     if (nib_cnt_q == 2'd1) state_d = ST_HTAR1;
                ST_HTAR1:     state_d = ST_HTAR2;
                ST_HTAR2:     state_d = ST_SYNC_WAIT;
                ST_SYNC_WAIT: if (wait_done) state_d = ST_SYNC_OK;
                ST_SYNC_OK:   state_d = dir_wr_q ? ST_TTAR : ST_RDATA_LO;
                ST_RDATA_LO:  state_d = ST_RDATA_HI;
                ST_RDATA_HI:  state_d = ST_TTAR;
                ST_TTAR:      state_d = ST_TFLOAT;
                ST_TFLOAT:    state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // Field capture
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            nib_cnt_q <= '0;
            dir_wr_q  <= 1'b0;
        end else begin
            nib_cnt_q <= '0;
            if (frame_n_i) begin
                unique case (state_q)
                    ST_CTYPE: dir_wr_q <= bus_nib_i[1];
                    ST_ADDR: begin
                        addr_q    <= addr_next;
                        nib_cnt_q <= nib_cnt_q + 2'd1;
                    end
                    ST_WDATA: begin
                        if (nib_cnt_q == 2'd0) wdata_q[3:0] <= bus_nib_i;
                        else                   wdata_q[7:4] <= bus_nib_i;
                        nib_cnt_q <= nib_cnt_q + 2'd1;
                    end
                    ST_HTAR1: if (!dir_wr_q) rdata_q <= loc_rdata_i;
                    default: ;
                endcase
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        bus_oe_o  = 1'b0;
        bus_nib_o = NIB_TAR;
        unique case (state_q)
            ST_SYNC_WAIT: begin bus_oe_o = 1'b1; bus_nib_o = NIB_WAIT;     end
            ST_SYNC_OK:   begin bus_oe_o = 1'b1; bus_nib_o = NIB_READY;    end
            ST_RDATA_LO:  begin bus_oe_o = 1'b1; bus_nib_o = rdata_q[3:0]; end
            ST_RDATA_HI:  begin bus_oe_o = 1'b1; bus_nib_o = rdata_q[7:4]; end
            ST_TTAR:      begin bus_oe_o = 1'b1; bus_nib_o = NIB_TAR;      end
            default: ;
        endcase
        loc_rd_o    = (state_q == ST_HTAR1) && !dir_wr_q;
        loc_wr_o    = (state_q == ST_HTAR1) &&  dir_wr_q;
        loc_addr_o  = addr_q;
        loc_wdata_o = wdata_q;
    end

    // R10: a low frame strobe releases the bus on the next clock
    p_abort_release_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !frame_n_i |=> !bus_oe_o);

    // R6: the ready sync comes only after the full wait run
    p_wait_before_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_SYNC_OK) |-> ($past(state_q) == ST_SYNC_WAIT) && $past(wait_done));

    // R7: the clock after a read ready sync carries the low data nibble
    p_rd_low_first_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_SYNC_OK && !dir_wr_q && frame_n_i) |=> bus_oe_o && (bus_nib_o == rdata_q[3:0]));

    // R5: local strobes only for addresses inside the window
    p_strobe_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (loc_wr_o || loc_rd_o) |-> ({1'b0, loc_addr_o} >= CHK_LO) && ({1'b0, loc_addr_o} < CHK_HI));

    // R9: after the target turnaround clock the bus is released
    p_release_after_tar_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_TTAR && frame_n_i) |=> !bus_oe_o);

    // R7/R8: the local strobe lasts a single clock
    p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (loc_wr_o || loc_rd_o) |=> !(loc_wr_o || loc_rd_o));
endmodule

// File: tb/lpcio_responder_bench.sv
module lpcio_responder_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n;
    logic [3:0]  nib_in;
    logic [3:0]  nib_out;
    logic        oe;
    logic [15:0] laddr;
    logic [7:0]  lwdata;
    logic        lwr;
    logic        lrd;
    logic [7:0]  lrdata;

    int n_tests = 0;
    int n_fails = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          wr;
        logic [15:0] a;
        logic [7:0]  d;
    } xfer_t;

    xfer_t exp_q[$];

    always #2.5 clk = ~clk;

    // local side model: byte returned depends on address
    assign lrdata = laddr[7:0] ^ 8'h5A;

    lpcio_responder u_lpcio_responder (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .frame_n_i   (frame_n),
        .bus_nib_i   (nib_in),
        .bus_nib_o   (nib_out),
        .bus_oe_o    (oe),
        .loc_addr_o  (laddr),
        .loc_wdata_o (lwdata),
        .loc_wr_o    (lwr),
        .loc_rd_o    (lrd),
        .loc_rdata_i (lrdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: every local strobe must match the next expected transfer
    always @(negedge clk) begin
        if (rst_n && (lrd || lwr)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected local strobe", int'(laddr), 0);
            end else begin
                xfer_t e;
                e = exp_q.pop_front();
                chk(lwr == e.wr, e.wr ? "R8" : "R7", "strobe kind", int'(lwr), int'(e.wr));
                chk(laddr == e.a, "R4", "local address", int'(laddr), int'(e.a));
                if (e.wr) chk(lwdata == e.d, "R8", "write byte", int'(lwdata), int'(e.d));
            end
        end
    end

    // Drives one host cycle (frame low one clock) and checks the target's reply
    task automatic host_cycle(input logic [3:0] start_nib, input logic [3:0] type_nib,
                              input logic [15:0] a, input logic [7:0] d,
                              input bit resp, input string miss_req);
        bit         wr     = type_nib[1];
        logic [7:0] rd_exp = a[7:0] ^ 8'h5A;
        int         len    = wr ? 8 : 10;
        bit         e_oe[10];
        logic [3:0] e_nib[10];
        string      e_req[10];
        if (resp) begin
            xfer_t it;
            it.wr = wr; it.a = a; it.d = d;
            exp_q.push_back(it);
        end
        e_oe[0] = 0; e_nib[0] = 4'hF; e_req[0] = "R6";
        e_oe[1] = 0; e_nib[1] = 4'hF; e_req[1] = "R6";
        for (int w = 2; w < 5; w++) begin e_oe[w] = 1; e_nib[w] = 4'h6; e_req[w] = "R6"; end
        e_oe[5] = 1; e_nib[5] = 4'h0; e_req[5] = "R6";
        if (!wr) begin
            e_oe[6] = 1; e_nib[6] = rd_exp[3:0]; e_req[6] = "R7";
            e_oe[7] = 1; e_nib[7] = rd_exp[7:4]; e_req[7] = "R7";
        end
        e_oe[len-2] = 1; e_nib[len-2] = 4'hF; e_req[len-2] = "R9";
        e_oe[len-1] = 0; e_nib[len-1] = 4'hF; e_req[len-1] = "R9";

        frame_n = 1'b0; nib_in = start_nib; step();
        frame_n = 1'b1; nib_in = type_nib;  step();
        for (int i = 0; i < 4; i++) begin
            nib_in = a[15-4*i -: 4];
            step();
        end
        if (wr) begin
            nib_in = d[3:0]; step();
            nib_in = d[7:4]; step();
        end
        for (int k = 0; k < len; k++) begin
            if (resp) begin
                chk(oe == e_oe[k], e_req[k], $sformatf("drive enable at reply clock %0d", k),
                    int'(oe), int'(e_oe[k]));
                if (e_oe[k]) chk(nib_out == e_nib[k], e_req[k],
                    $sformatf("nibble at reply clock %0d", k), int'(nib_out), int'(e_nib[k]));
            end else begin
                chk(!oe, miss_req, $sformatf("bus driven on ignored cycle clock %0d", k),
                    int'(oe), 0);
            end
            nib_in = 4'hF;
            step();
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_n = 1'b1; nib_in = 4'hF;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(!oe,  "R1", "drive enable after reset", int'(oe), 0);
        chk(!lrd, "R1", "read strobe after reset",  int'(lrd), 0);
        chk(!lwr, "R1", "write strobe after reset", int'(lwr), 0);
        repeat (2) step();
        chk(!oe,  "R1", "drive enable while idle", int'(oe), 0);

        // R7, R4: reads inside the window, both edges
        host_cycle(4'h0, 4'b0000, 16'h0060, 8'h00, 1'b1, "R5");
        host_cycle(4'h0, 4'b0001, 16'h006F, 8'h00, 1'b1, "R5");
        // R8: writes, low nibble first
        host_cycle(4'h0, 4'b0010, 16'h006F, 8'hA5, 1'b1, "R5");
        host_cycle(4'h0, 4'b0010, 16'h0068, 8'h3C, 1'b1, "R5");
        // R5: just outside the window
        host_cycle(4'h0, 4'b0000, 16'h005F, 8'h00, 1'b0, "R5");
        host_cycle(4'h0, 4'b0010, 16'h0070, 8'h99, 1'b0, "R5");
        // R3: a non-I/O type inside the window is ignored
        host_cycle(4'h0, 4'b0100, 16'h0061, 8'h00, 1'b0, "R3");
        host_cycle(4'h0, 4'b1010, 16'h0062, 8'h11, 1'b0, "R3");
        // R2: wrong start nibble
        host_cycle(4'h5, 4'b0000, 16'h0063, 8'h00, 1'b0, "R2");
        // R2: long frame, last nibble not start
        frame_n = 1'b0; nib_in = 4'h0; step();
        host_cycle(4'hA, 4'b0000, 16'h0063, 8'h00, 1'b0, "R2");
        // R2: long frame, last nibble is start
        frame_n = 1'b0; nib_in = 4'hA; step();
        host_cycle(4'h0, 4'b0000, 16'h0063, 8'h00, 1'b1, "R2");

        // R10: abort during wait syncs, then restart with a write
        begin
            xfer_t it;
            it.wr = 1'b0; it.a = 16'h0062; it.d = 8'h00;
            exp_q.push_back(it);
        end
        frame_n = 1'b0; nib_in = 4'h0; step();
        frame_n = 1'b1; nib_in = 4'h0; step();
        nib_in = 4'h0; step();
        nib_in = 4'h0; step();
        nib_in = 4'h6; step();
        nib_in = 4'h2; step();
        nib_in = 4'hF; step();
        step();
        chk(oe && nib_out == 4'h6, "R10", "first wait sync before abort", int'(nib_out), 6);
        frame_n = 1'b0; nib_in = 4'h0; step();
        chk(!oe, "R10", "drive enable one clock after abort", int'(oe), 0);
        host_cycle(4'h0, 4'b0010, 16'h0066, 8'h7E, 1'b1, "R10");

        // R10: abort during the address, then a read
        frame_n = 1'b0; nib_in = 4'h0; step();
        frame_n = 1'b1; nib_in = 4'h0; step();
        nib_in = 4'h0; step();
        nib_in = 4'h0; step();
        host_cycle(4'h0, 4'b0000, 16'h0064, 8'h00, 1'b1, "R10");

        step();
        chk(exp_q.size() == 0, "R7", "expected transfers left over", exp_q.size(), 0);
        chk(!oe, "R9", "bus released at end", int'(oe), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
        $finish;
    end
endmodule